// File: doc/BRIEF.md
# Fetch Thread Selector

In a multithreaded processor front end, only one hardware thread can use the instruction-fetch path in a given cycle. This block picks that thread. It looks at each thread's current fetch state, a mask of the threads that are active, and two per-thread occupancy counts: one for the instruction queue and one for the load/store queue. A two-bit policy input then decides how the thread is chosen. The result is a thread id plus a flag that is set when no thread may fetch. When that flag is set, the fetch logic does nothing for the cycle.

There are four policies. Round-robin keeps an ordered priority list inside the block and rotates it. The first usable thread in the list wins and then moves to the end of the list. The two occupancy policies pick the usable thread with the largest reported count. The solo policy always uses thread 0 and is meant only for builds with a single thread. A build with one thread ignores the policy entirely. The selection is combinational and depends only on the current inputs. The only state is the round-robin list, and it changes on the clock edge after a round-robin pick.

Top module: `fsel_thread_select`

## Requirements
- R1: A thread may be chosen only when its bit in `active_mask` is 1 and its 3-bit state code is 0 (running), 1 (idle) or 4 (line filled). Codes 2, 3, 5, 6 and 7 make the thread ineligible.
- R2: Under policy code 1 (round-robin), the priority list is scanned from its front, and the first eligible thread in it is selected.
- R3: After a round-robin cycle that selects a thread, that thread is at the back of the list from the next cycle on, and the other entries keep their relative order. Cycles under any other policy, and cycles with no selection, leave the list unchanged.
- R4: After reset, the priority list holds the thread ids in ascending order, with thread 0 at the front.
- R5: Under policy code 2, the eligible thread with the largest `iq_count` is selected. When counts are equal, the lower thread id wins.
- R6: Under policy code 3, the eligible thread with the largest `lsq_count` is selected. When counts are equal, the lower thread id wins.
- R7: When no thread is eligible, `sel_none` is 1 and `sel_tid` is 0.
- R8: In a build with one thread, thread 0 is returned whenever it is eligible under R1, whatever the policy. Otherwise `sel_none` is 1.
- R9: Policy code 0 (solo) selects thread 0 when thread 0 is eligible. Using it in a build with more than one thread is illegal.
- R10: `sel_tid` and `sel_none` follow the inputs within the same cycle. A change to the priority list becomes visible only after the next rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| policy | input | 2 | 0 solo, 1 round-robin, 2 instruction-queue count, 3 load/store-queue count |
| thr_state | input | 3*NUM_THREADS | Per-thread fetch state codes; thread t occupies bits [3t+2:3t] |
| active_mask | input | NUM_THREADS | One bit per thread; 1 means the thread is active |
| iq_count | input | CNT_W*NUM_THREADS | Per-thread instruction-queue occupancy |
| lsq_count | input | CNT_W*NUM_THREADS | Per-thread load/store-queue occupancy |
| sel_tid | output | max(1,clog2(NUM_THREADS)) | Selected thread id |
| sel_none | output | 1 | 1 when no thread may fetch this cycle |

## Verification
The selection outputs are combinational. They are due in the same cycle the inputs are applied, so the bench drives each input set on the falling edge and samples the outputs 2 ns later, before the next rising edge. The effect of a round-robin pick on the priority list is due one rising edge later. The bench updates its own model of the list after each sampled pick, so the next cycle's check observes the rotated order through `sel_tid`. A second instance, built with one thread, is swept over every state code, mask bit and policy in the same way.

// File: rtl/fsel_pkg.sv
package fsel_pkg;

    localparam int STATE_W = 3;

    typedef enum logic [STATE_W-1:0] {
        TS_RUN        = 3'd0,
        TS_IDLE       = 3'd1,
        TS_SQUASH     = 3'd2,
        TS_STALL      = 3'd3,
        TS_FILLED     = 3'd4,
        TS_WAIT_RESP  = 3'd5,
        TS_WAIT_RETRY = 3'd6,
        TS_OFF        = 3'd7
    } thr_state_e;

    typedef enum logic [1:0] {
        POL_SOLO = 2'd0,
        POL_RR   = 2'd1,
        POL_IQ   = 2'd2,
        POL_LSQ  = 2'd3
    } fetch_pol_e;

endpackage

// File: rtl/fsel_elig.sv
module fsel_elig
    import fsel_pkg::*;
#(
    parameter int NUM_THREADS = 4
) (
    input  logic [NUM_THREADS*STATE_W-1:0] thr_state,
    input  logic [NUM_THREADS-1:0]         active_mask,
    output logic [NUM_THREADS-1:0]         elig
);

    for (genvar t = 0; t < NUM_THREADS; t++) begin : g_thr
        thr_state_e st;
        assign st = thr_state_e'(thr_state[t*STATE_W +: STATE_W]);
        // R1: inactive threads are masked before any policy is applied
        assign elig[t] = active_mask[t] &&
                         (st == TS_RUN || st == TS_IDLE || st == TS_FILLED);
    end

endmodule

// File: rtl/fsel_rr_list.sv
module fsel_rr_list #(
    parameter int NUM_THREADS = 4,
    parameter int TID_W       = 2
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [NUM_THREADS-1:0] elig,
    input  logic                   advance,
    output logic [TID_W-1:0]       pick_tid,
    output logic                   pick_ok
);

    typedef struct packed {
        logic [NUM_THREADS-1:0][TID_W-1:0] order;
    } rr_state_t;

    rr_state_t st_d, st_q;
    int        pick_pos;

    always_comb begin
        pick_ok  = 1'b0;
        pick_tid = '0;
        pick_pos = 0;
        for (int i = 0; i < NUM_THREADS; i++) begin
            if (!pick_ok && elig[st_q.order[i]]) begin
                pick_ok  = 1'b1;
                pick_tid = st_q.order[i];
                pick_pos = i;
            end
        end
        st_d = st_q;
        if (advance && pick_ok) begin
            for (int i = 0; i < NUM_THREADS - 1; i++) begin
                if (i >= pick_pos) st_d.order[i] = st_q.order[i+1];
            end
            st_d.order[NUM_THREADS-1] = pick_tid;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NUM_THREADS; i++) st_q.order[i] <= TID_W'(i);
        end else begin
            st_q <= st_d;
        end
    end

    logic perm_ok;
    always_comb begin
        perm_ok = 1'b1;
        for (int j = 0; j < NUM_THREADS; j++) begin
            int hits;
            hits = 0;
            for (int i = 0; i < NUM_THREADS; i++)
                if (int'(st_q.order[i]) == j) hits++;
            if (hits != 1) perm_ok = 1'b0;
        end
    end

    // R3
    rr_to_back_chk: assert property (@(posedge clk) disable iff (rst)
        (advance && pick_ok) |=> (st_q.order[NUM_THREADS-1] == $past(pick_tid)));

    // R3
    rr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !(advance && pick_ok) |=> $stable(st_q));

    // R4
    rr_perm_chk: assert property (@(posedge clk) disable iff (rst) perm_ok);

endmodule

// File: rtl/fsel_max_pick.sv
module fsel_max_pick #(
    parameter int NUM_THREADS = 4,
    parameter int CNT_W       = 6,
    parameter int TID_W       = 2
) (
    input  logic [NUM_THREADS-1:0]       elig,
    input  logic [NUM_THREADS*CNT_W-1:0] counts,
    output logic [TID_W-1:0]             pick_tid,
    output logic                         pick_ok
);

    logic [CNT_W-1:0] best;

    always_comb begin
        pick_ok  = 1'b0;
        pick_tid = '0;
        best     = '0;
        for (int t = 0; t < NUM_THREADS; t++) begin
            // R5 R6: strict compare keeps the lower id on a tie
            if (elig[t] && (!pick_ok || counts[t*CNT_W +: CNT_W] > best)) begin
                pick_ok  = 1'b1;
                pick_tid = TID_W'(t);
                best     = counts[t*CNT_W +: CNT_W];
            end
        end
    end

endmodule

// File: rtl/fsel_thread_select.sv
module fsel_thread_select
    import fsel_pkg::*;
#(
    parameter int NUM_THREADS = 4,
    parameter int CNT_W       = 6,
    localparam int TID_W      = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic [1:0]                     policy,
    input  logic [NUM_THREADS*STATE_W-1:0] thr_state,
    input  logic [NUM_THREADS-1:0]         active_mask,
    input  logic [NUM_THREADS*CNT_W-1:0]   iq_count,
    input  logic [NUM_THREADS*CNT_W-1:0]   lsq_count,
    output logic [TID_W-1:0]               sel_tid,
    output logic                           sel_none
);

    logic [NUM_THREADS-1:0] elig;

    fsel_elig #(.NUM_THREADS(NUM_THREADS)) u_elig (
        .thr_state   (thr_state),
        .active_mask (active_mask),
        .elig        (elig)
    );

    if (NUM_THREADS == 1) begin : g_one
        // R8: a single configured thread bypasses the policy
        always_comb begin
            sel_tid  = '0;
            sel_none = !elig[0];
        end
    end else begin : g_multi
        fetch_pol_e                 pol;
        logic [TID_W-1:0]           rr_tid, mx_tid;
        logic                       rr_ok, mx_ok;
        logic [NUM_THREADS*CNT_W-1:0] pol_cnt;

        assign pol     = fetch_pol_e'(policy);
        assign pol_cnt = (pol == POL_LSQ) ? lsq_count : iq_count;

        fsel_rr_list #(.NUM_THREADS(NUM_THREADS), .TID_W(TID_W)) u_rr (
            .clk      (clk),
            .rst      (rst),
            .elig     (elig),
            .advance  (pol == POL_RR),
            .pick_tid (rr_tid),
            .pick_ok  (rr_ok)
        );

        fsel_max_pick #(.NUM_THREADS(NUM_THREADS), .CNT_W(CNT_W), .TID_W(TID_W)) u_max (
            .elig     (elig),
            .counts   (pol_cnt),
            .pick_tid (mx_tid),
            .pick_ok  (mx_ok)
        );

        always_comb begin
            sel_tid  = '0;
            sel_none = 1'b1;
            unique case (pol)
                POL_SOLO: sel_none = !elig[0];
                POL_RR: begin
                    sel_tid  = rr_ok ? rr_tid : '0;
                    sel_none = !rr_ok;
                end
                default: begin
                    sel_tid  = mx_ok ? mx_tid : '0;
                    sel_none = !mx_ok;
                end
            endcase
        end

        logic beaten;
        always_comb begin
            beaten = 1'b0;
            for (int j = 0; j < NUM_THREADS; j++) begin
                if (elig[j] &&
                    (pol_cnt[j*CNT_W +: CNT_W] > pol_cnt[int'(sel_tid)*CNT_W +: CNT_W] ||
                     (pol_cnt[j*CNT_W +: CNT_W] == pol_cnt[int'(sel_tid)*CNT_W +: CNT_W] &&
                      j < int'(sel_tid))))
                    beaten = 1'b1;
            end
        end

        // R5 R6
        max_pick_chk: assert property (@(posedge clk) disable iff (rst)
            ((pol == POL_IQ || pol == POL_LSQ) && !sel_none) |-> !beaten);

        // R9
        solo_illegal_chk: assert property (@(posedge clk) disable iff (rst)
            pol != POL_SOLO);
    end

    thr_state_e sel_st;
    assign sel_st = thr_state_e'(thr_state[int'(sel_tid)*STATE_W +: STATE_W]);

    // R1
    sel_legal_chk: assert property (@(posedge clk) disable iff (rst)
        !sel_none |-> (active_mask[sel_tid] &&
                       (sel_st == TS_RUN || sel_st == TS_IDLE || sel_st == TS_FILLED)));

    // R7
    none_chk: assert property (@(posedge clk) disable iff (rst)
        (elig == '0) |-> (sel_none && sel_tid == '0));

endmodule

// File: tb/fsel_thread_select_test.sv
module fsel_thread_select_test;
    localparam int N  = 4;
    localparam int CW = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #10 clk = ~clk;

    logic [1:0]      pol;
    logic [N*3-1:0]  st;
    logic [N-1:0]    act;
    logic [N*CW-1:0] iq, lsq;
    logic [1:0]      tid;
    logic            none;

    logic [1:0]      pol1;
    logic [2:0]      st1;
    logic            act1;
    logic [CW-1:0]   iq1, lsq1;
    logic            tid1;
    logic            none1;

    fsel_thread_select #(.NUM_THREADS(N), .CNT_W(CW)) uut (
        .clk(clk), .rst(rst), .policy(pol), .thr_state(st), .active_mask(act),
        .iq_count(iq), .lsq_count(lsq), .sel_tid(tid), .sel_none(none)
    );

    fsel_thread_select #(.NUM_THREADS(1), .CNT_W(CW)) uut1 (
        .clk(clk), .rst(rst), .policy(pol1), .thr_state(st1), .active_mask(act1),
        .iq_count(iq1), .lsq_count(lsq1), .sel_tid(tid1), .sel_none(none1)
    );

    int checks = 0;
    int fails  = 0;
    bit done   = 0;
    int mlist[N];

    task automatic check(string req, int a, int e);
        checks++;
        if (a != e) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, a, e);
        end
    endtask

    function automatic bit ok_state(logic [2:0] s);
        return s == 3'd0 || s == 3'd1 || s == 3'd4;
    endfunction

    // drive happens at the falling edge; outputs are sampled 2 ns later
    task automatic step(string req);
        bit e[N];
        bit en;
        int et, pos, best;
        logic [N*CW-1:0] c;
        #2;
        for (int t = 0; t < N; t++) e[t] = act[t] && ok_state(st[t*3 +: 3]);
        en = 0; et = 0; pos = 0; best = -1;
        c = (pol == 2'd3) ? lsq : iq;
        if (pol == 2'd1) begin
            for (int i = 0; i < N; i++)
                if (!en && e[mlist[i]]) begin en = 1; et = mlist[i]; pos = i; end
        end else begin
            for (int t = 0; t < N; t++)
                if (e[t] && int'(c[t*CW +: CW]) > best) begin
                    en = 1; et = t; best = int'(c[t*CW +: CW]);
                end
        end
        check({req, " sel_tid"}, int'(tid), et);
        check({req, " sel_none"}, int'(none), int'(!en));
        // R8 single-thread build, any policy
        check("R8 single-build sel_none", int'(none1), int'(!(act1 && ok_state(st1))));
        check("R8 single-build sel_tid", int'(tid1), 0);
        if (pol == 2'd1 && en) begin
            for (int i = pos; i < N - 1; i++) mlist[i] = mlist[i+1];
            mlist[N-1] = et;
        end
    endtask

    task automatic all_ready();
        st = '0; act = '1; iq = '0; lsq = '0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < N; i++) mlist[i] = i;
        pol = 2'd1; all_ready();
        pol1 = 2'd0; st1 = 3'd0; act1 = 1'b1; iq1 = '0; lsq1 = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R4 reset order, then R2 R3 rotation 0,1,2,3,0 (R10 one edge later)
        step("R4");
        for (int k = 0; k < 4; k++) begin
            @(negedge clk); step("R3");
        end

        // R7 nothing eligible: no pick and no list change
        @(negedge clk); act = '0; step("R7");
        @(negedge clk); all_ready(); st = {N{3'd3}}; step("R7");
        @(negedge clk); all_ready(); step("R2");

        // R1 each ineligible code on all but thread 2, every policy
        for (int p = 1; p < 4; p++) begin
            for (int s = 0; s < 8; s++) begin
                @(negedge clk);
                all_ready(); pol = 2'(p);
                for (int t = 0; t < N; t++) if (t != 2) st[t*3 +: 3] = 3'(s);
                step("R1");
            end
        end

        // R5 R6 ties go to lower id
        @(negedge clk); all_ready(); pol = 2'd2; iq = {4'd5, 4'd5, 4'd5, 4'd5}; step("R5");
        @(negedge clk); act = 4'b1100; step("R5");
        @(negedge clk); all_ready(); pol = 2'd3; lsq = {4'd9, 4'd2, 4'd9, 4'd1}; step("R6");
        @(negedge clk); iq = {4'd15, 4'd0, 4'd0, 4'd0}; step("R6");

        // sweep of mixed patterns; R3 holds the list across non-round-robin cycles
        for (int k = 0; k < 3000; k++) begin
            @(negedge clk);
            pol = 2'(1 + ($urandom % 3));
            act = 4'($urandom);
            for (int t = 0; t < N; t++)
                st[t*3 +: 3] = ($urandom % 2) ? 3'd0 + 3'(($urandom % 2) * (1 + 3 * ($urandom % 2)))
                                              : 3'($urandom);
            iq  = 16'($urandom) & 16'h3333;
            lsq = 16'($urandom) & 16'h3333;
            pol1 = 2'($urandom); st1 = 3'($urandom); act1 = 1'($urandom);
            case (pol)
                2'd1:    step("R3 R2");
                2'd2:    step("R5");
                default: step("R6");
            endcase
        end

        // R9 R8 exhaustive single-thread build
        for (int p = 0; p < 4; p++)
            for (int s = 0; s < 8; s++)
                for (int a = 0; a < 2; a++) begin
                    @(negedge clk);
                    pol1 = 2'(p); st1 = 3'(s); act1 = 1'(a);
                    step("R9");
                end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule